// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, arranged as three banks of 32, and resolves them onto two processor-facing outputs: a normal interrupt request (`irq_o`) and a fast interrupt request (`fiq_o`). Each line is steered to one of the two classes and carries a 6-bit priority. When an output is armed and an unmasked line of its class is pending, the controller makes an agreement. It latches the winning line number into a code register, raises the output, and disarms that class. Software reads the code, services the source, and writes a re-arm bit. The re-arm drops the output and evaluates the class again.

Software programs the block through a 4 KB word-addressed register space. Each bank has a strided group of registers: raw inputs, a mask with atomic set and clear aliases, software interrupt set and clear, and pending readbacks split by class. A global mask blocks new agreements. A soft-reset bit returns the whole block to its reset state in one cycle. The autoidle and idle fields are stored only.

Top module: `intc3_top`

## Requirements
- R1: After the reset pin, and in the cycle after a soft reset, every mask reads 0xFFFFFFFF and every line configuration reads 0. The software, raw and pending bits are cleared. Both codes, the control register, the config register and the idle register read 0. `irq_o` and `fiq_o` are low.
- R2: Address 0x00 reads 0x21 and address 0x14 reads 1. Writes to these, to the codes at 0x40/0x44, to raw input and to the pending readbacks change nothing.
- R3: Bank b has its registers at 0x80+0x20*b, with these offsets:
  - 0x00 raw input
  - 0x04 mask
  - 0x08 mask clear
  - 0x0C mask set
  - 0x10 software set (reads back the software bits)
  - 0x14 software clear
  - 0x18 pending IRQ
  - 0x1C pending FIQ

  A bank index of 3 or above reads 0 and ignores writes.
- R4: The configuration of global line n is at 0x100+4*n. Bit 0 selects FIQ (1) or IRQ (0), and bits 7:2 hold the priority. The written value reads back.
- R5: Pending IRQ reads pending & ~mask & ~fiq. Pending FIQ reads pending & ~mask & fiq.
- R6: A rising line sets its raw and pending bits and triggers evaluation. When any line of a bank falls, that bank's pending becomes raw | software.
- R7: A software-set write ORs into both the software and pending bits and triggers evaluation. A software-clear write clears software bits, then sets pending to software & raw, with no evaluation.
- R8: Mask writes and mask-clear writes trigger evaluation of both classes. Mask-set writes do not.
- R9: An output rises only on an evaluation while its class is armed and has an unmasked pending line. The code is then captured and held until the next re-arm. Control bit 0 re-arms IRQ and bit 1 re-arms FIQ; each drops its output, then evaluates.
- R10: The lowest priority value wins. Among equal priorities, the highest line number wins.
- R11: Control bit 2 at 0x48 is the global mask and reads back at bit 2. While it is set, no agreement is made. Clearing it alone does not trigger evaluation.
- R12: Config at 0x10 stores an autoidle bit from bit 0, and writing bit 1 performs the soft reset. Idle at 0x50 stores 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational, no side effects |
| line_in | input | 96 | Level interrupt lines, bank b on bits 32b+31:32b |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is an armed class whose pending line sits masked or globally blocked, so that only one specific event can cause the agreement. The stimulus first re-arms with no active source, then sets the global mask or a mask bit. It then raises the line and shows that the output stays low. A re-arm or a mask-clear write then releases it. Priority ties are forced by giving lines in two different banks the same priority. Both are raised while the output is disarmed, so that a single re-arm has to choose between them.

// File: rtl/intc3_pkg.sv
package intc3_pkg;

  localparam int LANES = 32;

  localparam logic [11:0] A_REV      = 12'h000;
  localparam logic [11:0] A_CFG      = 12'h010;
  localparam logic [11:0] A_STAT     = 12'h014;
  localparam logic [11:0] A_CODE_IRQ = 12'h040;
  localparam logic [11:0] A_CODE_FIQ = 12'h044;
  localparam logic [11:0] A_CTL      = 12'h048;
  localparam logic [11:0] A_IDLE     = 12'h050;
  localparam logic [11:0] A_LINE     = 12'h100;

  typedef enum logic [2:0] {
    SL_RAW  = 3'd0,
    SL_MASK = 3'd1,
    SL_MCLR = 3'd2,
    SL_MSET = 3'd3,
    SL_SSET = 3'd4,
    SL_SCLR = 3'd5,
    SL_PIRQ = 3'd6,
    SL_PFIQ = 3'd7
  } slot_e;

  typedef struct packed {
    logic wr_mask;
    logic wr_mclr;
    logic wr_mset;
    logic wr_sset;
    logic wr_sclr;
  } bank_op_t;

  // pending after the line inputs of one cycle are taken in
  function automatic logic [LANES-1:0] pend_on_lines(
      logic [LANES-1:0] pend, logic [LANES-1:0] raw_old,
      logic [LANES-1:0] raw_new, logic [LANES-1:0] swi);
    logic [LANES-1:0] up;
    up = raw_new & ~raw_old;
    if (|(raw_old & ~raw_new)) return raw_new | swi;
    return pend | up;
  endfunction

  function automatic logic [LANES-1:0] mask_update(
      logic [LANES-1:0] mask, logic [LANES-1:0] wd, bank_op_t op);
    logic [LANES-1:0] m;
    m = mask;
    if (op.wr_mask) m = wd;
    if (op.wr_mclr) m = mask & ~wd;
    if (op.wr_mset) m = mask | wd;
    return m;
  endfunction

endpackage

// File: rtl/intc3_decode.sv
module intc3_decode
  import intc3_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int NLINE = 96,
  localparam int LIDX_W = $clog2(NLINE)
) (
  input  logic              wr,
  input  logic [11:0]       addr,
  output bank_op_t          bop [NBANK],
  output logic              bank_hit,
  output logic [1:0]        bank_idx,
  output slot_e             slot,
  output logic              line_hit,
  output logic [LIDX_W-1:0] line_idx,
  output logic              wr_line,
  output logic              wr_ctl,
  output logic              wr_cfg,
  output logic              wr_idle
);
  logic [11:0] loff;

  assign bank_idx = addr[6:5];
  assign slot     = slot_e'(addr[4:2]);
  assign bank_hit = (addr[11:7] == 5'b00001) && (32'(bank_idx) < NBANK);

  assign loff     = addr - A_LINE;
  assign line_hit = (addr >= A_LINE) && (32'(loff[11:2]) < NLINE);
  assign line_idx = loff[2 +: LIDX_W];

  assign wr_line = wr && line_hit;
  assign wr_ctl  = wr && (addr[11:2] == A_CTL[11:2]);
  assign wr_cfg  = wr && (addr[11:2] == A_CFG[11:2]);
  assign wr_idle = wr && (addr[11:2] == A_IDLE[11:2]);

  for (genvar b = 0; b < NBANK; b++) begin : g_op
    logic sel;
    assign sel = wr && bank_hit && (bank_idx == 2'(b));
    assign bop[b] = {sel && slot == SL_MASK, sel && slot == SL_MCLR,
                     sel && slot == SL_MSET, sel && slot == SL_SSET,
                     sel && slot == SL_SCLR};
  end
endmodule

// File: rtl/intc3_bank.sv
module intc3_bank
  import intc3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [LANES-1:0] lines,
  input  bank_op_t         op,
  input  logic [LANES-1:0] wd,
  output logic [LANES-1:0] raw_q,
  output logic [LANES-1:0] pend_q,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] swi_q,
  output logic [LANES-1:0] pend_n,
  output logic [LANES-1:0] mask_n,
  output logic             rise_any
);
  logic [LANES-1:0] swi_n, pend_l;

  assign rise_any = |(lines & ~raw_q);

  always_comb begin
    pend_l = pend_on_lines(pend_q, raw_q, lines, swi_q);
    swi_n  = swi_q;
    pend_n = pend_l;
    if (op.wr_sset) begin
      swi_n  = swi_q | wd;
      pend_n = pend_l | swi_n;
    end
    if (op.wr_sclr) begin
      swi_n  = swi_q & ~wd;
      pend_n = swi_n & lines;
    end
    mask_n = mask_update(mask_q, wd, op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0; pend_q <= '0; mask_q <= '1; swi_q <= '0;
    end else if (srst) begin
      raw_q <= '0; pend_q <= '0; mask_q <= '1; swi_q <= '0;
    end else begin
      raw_q <= lines; pend_q <= pend_n; mask_q <= mask_n; swi_q <= swi_n;
    end
  end
endmodule

// File: rtl/intc3_resolve.sv
module intc3_resolve #(
  parameter int NLINE  = 96,
  parameter int PRIO_W = 6,
  localparam int CODE_W = $clog2(NLINE)
) (
  input  logic [NLINE-1:0]  act,
  input  logic [PRIO_W-1:0] prio [NLINE],
  output logic              any,
  output logic [CODE_W-1:0] code
);
  // later lines take ties: a candidate wins when its value is not above the best
  function automatic logic takes_over(logic have, logic [PRIO_W-1:0] best,
                                      logic [PRIO_W-1:0] p);
    return !have || (p <= best);
  endfunction

  logic [PRIO_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    best = '0;
    code = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (act[i] && takes_over(any, best, prio[i])) begin
        any  = 1'b1;
        best = prio[i];
        code = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc3_top.sv
module intc3_top
  import intc3_pkg::*;
#(
  parameter int          NBANK  = 3,
  parameter int          PRIO_W = 6,
  parameter logic [7:0]  REV_ID = 8'h21,
  localparam int NLINE  = NBANK * LANES,
  localparam int CODE_W = $clog2(NLINE),
  localparam int LIDX_W = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NLINE-1:0] line_in,
  output logic             irq_o,
  output logic             fiq_o
);
  bank_op_t          bop [NBANK];
  logic              bank_hit, line_hit, wr_line, wr_ctl, wr_cfg, wr_idle;
  logic [1:0]        bank_idx;
  slot_e             slot;
  logic [LIDX_W-1:0] line_idx;

  intc3_decode #(.NBANK(NBANK), .NLINE(NLINE)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .bop(bop), .bank_hit(bank_hit),
    .bank_idx(bank_idx), .slot(slot), .line_hit(line_hit), .line_idx(line_idx),
    .wr_line(wr_line), .wr_ctl(wr_ctl), .wr_cfg(wr_cfg), .wr_idle(wr_idle));

  // soft reset event
  logic srst;
  assign srst = wr_cfg && bus_wdata[1];

  logic [NLINE-1:0] raw_all, pend_all, mask_all, swi_all, pend_nx, mask_nx;
  logic [NBANK-1:0] rise_vec, bank_evt;
  logic             mset_any;
  logic [NBANK-1:0] mset_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc3_bank u_bank (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .lines(line_in[b*LANES +: LANES]), .op(bop[b]), .wd(bus_wdata),
      .raw_q(raw_all[b*LANES +: LANES]), .pend_q(pend_all[b*LANES +: LANES]),
      .mask_q(mask_all[b*LANES +: LANES]), .swi_q(swi_all[b*LANES +: LANES]),
      .pend_n(pend_nx[b*LANES +: LANES]), .mask_n(mask_nx[b*LANES +: LANES]),
      .rise_any(rise_vec[b]));
    assign bank_evt[b] = rise_vec[b] | bop[b].wr_mask | bop[b].wr_mclr | bop[b].wr_sset;
    assign mset_vec[b] = bop[b].wr_mset;
  end
  assign mset_any = |mset_vec;

  // per-line class and priority
  logic [NLINE-1:0]  fiq_q;
  logic [PRIO_W-1:0] prio_q [NLINE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q <= '0;
      for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
    end else if (srst) begin
      fiq_q <= '0;
      for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
    end else if (wr_line) begin
      fiq_q[line_idx]  <= bus_wdata[0];
      prio_q[line_idx] <= bus_wdata[2 +: PRIO_W];
    end
  end

  // class 0 = IRQ, class 1 = FIQ
  logic [NLINE-1:0]  act    [2];
  logic              win_any [2];
  logic [CODE_W-1:0] win_code [2];

  assign act[0] = pend_nx & ~mask_nx & ~fiq_q;
  assign act[1] = pend_nx & ~mask_nx & fiq_q;

  for (genvar c = 0; c < 2; c++) begin : g_res
    intc3_resolve #(.NLINE(NLINE), .PRIO_W(PRIO_W)) u_res (
      .act(act[c]), .prio(prio_q), .any(win_any[c]), .code(win_code[c]));
  end

  logic              gmask_q, gmask_n, autoidle_q;
  logic [1:0]        idle_q, arm_q, out_q, rearm, fire, arm_mid, out_mid;
  logic [CODE_W-1:0] code_q [2];
  logic              evt_any;

  assign gmask_n = wr_ctl ? bus_wdata[2] : gmask_q;
  assign evt_any = |bank_evt;

  for (genvar c = 0; c < 2; c++) begin : g_agr
    assign rearm[c]   = wr_ctl && bus_wdata[c];
    assign arm_mid[c] = arm_q[c] | rearm[c];
    assign out_mid[c] = rearm[c] ? 1'b0 : out_q[c];
    assign fire[c]    = (evt_any | rearm[c]) & arm_mid[c] & win_any[c] & ~gmask_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b0; arm_q <= 2'b11; out_q <= 2'b00;
      code_q[0] <= '0; code_q[1] <= '0; autoidle_q <= 1'b0; idle_q <= 2'b00;
    end else if (srst) begin
      gmask_q <= 1'b0; arm_q <= 2'b11; out_q <= 2'b00;
      code_q[0] <= '0; code_q[1] <= '0; autoidle_q <= 1'b0; idle_q <= 2'b00;
    end else begin
      gmask_q <= gmask_n;
      for (int c = 0; c < 2; c++) begin
        arm_q[c] <= fire[c] ? 1'b0 : arm_mid[c];
        out_q[c] <= fire[c] ? 1'b1 : out_mid[c];
        if (fire[c]) code_q[c] <= win_code[c];
      end
      if (wr_cfg)  autoidle_q <= bus_wdata[0];
      if (wr_idle) idle_q     <= bus_wdata[1:0];
    end
  end

  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  // current-state view for the checker
  logic live_irq_any;
  assign live_irq_any = |(pend_all & ~mask_all & ~fiq_q);

  // read mux
  logic [6:0] bsel;
  assign bsel = {bank_idx, 5'b0};

  always_comb begin
    bus_rdata = '0;
    if (bank_hit) begin
      case (slot)
        SL_RAW:  bus_rdata = raw_all[bsel +: LANES];
        SL_MASK: bus_rdata = mask_all[bsel +: LANES];
        SL_SSET: bus_rdata = swi_all[bsel +: LANES];
        SL_PIRQ: bus_rdata = pend_all[bsel +: LANES] & ~mask_all[bsel +: LANES]
                             & ~fiq_q[bsel +: LANES];
        SL_PFIQ: bus_rdata = pend_all[bsel +: LANES] & ~mask_all[bsel +: LANES]
                             & fiq_q[bsel +: LANES];
        default: bus_rdata = '0;
      endcase
    end else if (line_hit) begin
      bus_rdata[0]          = fiq_q[line_idx];
      bus_rdata[2 +: PRIO_W] = prio_q[line_idx];
    end else begin
      case (bus_addr[11:2])
        A_REV[11:2]:      bus_rdata = 32'(REV_ID);
        A_CFG[11:2]:      bus_rdata = {31'd0, autoidle_q};
        A_STAT[11:2]:     bus_rdata = 32'd1;
        A_CODE_IRQ[11:2]: bus_rdata = 32'(code_q[0]);
        A_CODE_FIQ[11:2]: bus_rdata = 32'(code_q[1]);
        A_CTL[11:2]:      bus_rdata = {29'd0, gmask_q, 2'b00};
        A_IDLE[11:2]:     bus_rdata = {30'd0, idle_q};
        default:          bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc3_chk.sv
module intc3_chk #(
  parameter int NLINE  = 96,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              gmask_q,
  input logic [1:0]        arm_q,
  input logic [1:0]        rearm,
  input logic              srst,
  input logic              mset_any,
  input logic              evt_any,
  input logic              live_irq_any,
  input logic [CODE_W-1:0] code_irq
);
  assert_srst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!irq_o && !fiq_o));

  assert_gmask_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !gmask_q);

  assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q[0] && !rearm[0] && !srst) |=> $stable(code_irq));

  assert_rise_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> live_irq_any);

  assert_mset_no_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_any && !evt_any && !irq_o) |=> !irq_o);

  always_comb begin
    if (rst_n) assert_code_range_R10: assert (32'(code_irq) < NLINE);
  end
endmodule

bind intc3_top intc3_chk #(.NLINE(NLINE), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o), .gmask_q(gmask_q),
  .arm_q(arm_q), .rearm(rearm), .srst(srst), .mset_any(mset_any),
  .evt_any(evt_any), .live_irq_any(live_irq_any), .code_irq(code_q[0]));

// File: tb/sim_intc3_top.sv
module sim_intc3_top;
  localparam int NL = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [NL-1:0] line_in = '0;
  wire  [31:0]   bus_rdata;
  wire           irq_o, fiq_o;

  intc3_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
    .irq_o(irq_o), .fiq_o(fiq_o));

  always #10 clk = ~clk;

  // kind 0 = read data, 1 = irq_o, 2 = fiq_o
  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    item_t it;
    logic [31:0] got;
    if (sbq.size() > 0) begin
      it  = sbq.pop_front();
      got = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'd0, irq_o} : {31'd0, fiq_o};
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    bus_addr = a;
    sbq.push_back('{0, e, tag});
  endtask

  task automatic chk_pin(input int k, input logic e, input string tag);
    @(negedge clk); #1;
    sbq.push_back('{k, {31'd0, e}, tag});
  endtask

  task automatic set_line(input int idx, input logic v);
    @(negedge clk); #1;
    line_in[idx] = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2 reset state and identification
    chk_rd(12'h000, 32'h21, "R2 revision");
    chk_rd(12'h014, 32'h1, "R2 status");
    chk_rd(12'h084, 32'hFFFF_FFFF, "R1 mask reset bank0");
    chk_rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask reset bank2");
    chk_rd(12'h040, 32'h0, "R1 irq code reset");
    chk_pin(1, 1'b0, "R1 irq_o reset");
    chk_pin(2, 1'b0, "R1 fiq_o reset");
    // R4 line config
    wr(12'h114, 32'h0C);
    chk_rd(12'h114, 32'h0C, "R4 line5 cfg");
    // R6 rise and agreement
    wr(12'h088, 32'h20);
    set_line(5, 1'b1);
    chk_pin(1, 1'b1, "R6 irq after rise");
    chk_rd(12'h040, 32'd5, "R9 code captured");
    chk_rd(12'h080, 32'h20, "R6 raw bank0");
    chk_rd(12'h098, 32'h20, "R5 pending irq bank0");
    // R9 held until re-arm; R10 priority
    wr(12'h1A0, 32'h04);
    wr(12'h0A8, 32'h100);
    set_line(40, 1'b1);
    chk_rd(12'h040, 32'd5, "R9 code held while disarmed");
    chk_rd(12'h0B8, 32'h100, "R5 pending irq bank1");
    wr(12'h048, 32'h1);
    chk_pin(1, 1'b1, "R9 irq after rearm");
    chk_rd(12'h040, 32'd40, "R10 lower priority value wins");
    wr(12'h218, 32'h04);
    wr(12'h0C8, 32'h40);
    set_line(70, 1'b1);
    wr(12'h048, 32'h1);
    chk_rd(12'h040, 32'd70, "R10 tie goes to higher line");
    // FIQ class
    wr(12'h108, 32'h01);
    chk_rd(12'h108, 32'h01, "R4 line2 fiq cfg");
    wr(12'h084, 32'hFFFF_FFDB);
    chk_pin(2, 1'b0, "R9 fiq idle before source");
    set_line(2, 1'b1);
    chk_pin(2, 1'b1, "R9 fiq raised");
    chk_rd(12'h044, 32'd2, "R9 fiq code");
    chk_rd(12'h09C, 32'h4, "R5 pending fiq bank0");
    chk_rd(12'h098, 32'h20, "R5 pending irq excludes fiq");
    // R6 deassertion
    @(negedge clk); #1;
    line_in[2] = 1'b0; line_in[5] = 1'b0; line_in[40] = 1'b0; line_in[70] = 1'b0;
    wr(12'h048, 32'h3);
    chk_pin(1, 1'b0, "R6 irq low after fall and rearm");
    chk_pin(2, 1'b0, "R6 fiq low after fall and rearm");
    chk_rd(12'h098, 32'h0, "R6 pending cleared bank0");
    chk_rd(12'h0D8, 32'h0, "R6 pending cleared bank2");
    // R7 software interrupts
    wr(12'h090, 32'h20);
    chk_pin(1, 1'b1, "R7 swi set raises irq");
    chk_rd(12'h040, 32'd5, "R7 swi code");
    chk_rd(12'h090, 32'h20, "R7 swi readback");
    wr(12'h094, 32'h20);
    chk_rd(12'h098, 32'h0, "R7 swi clear pending");
    chk_rd(12'h090, 32'h0, "R7 swi cleared");
    chk_pin(1, 1'b1, "R7 swi clear keeps output");
    wr(12'h048, 32'h1);
    chk_pin(1, 1'b0, "R9 rearm drops output");
    // R11 global mask
    wr(12'h048, 32'h4);
    chk_rd(12'h048, 32'h4, "R11 gmask readback");
    set_line(5, 1'b1);
    chk_pin(1, 1'b0, "R11 gmask blocks agreement");
    wr(12'h048, 32'h0);
    chk_pin(1, 1'b0, "R11 gmask clear alone no eval");
    wr(12'h048, 32'h1);
    chk_pin(1, 1'b1, "R11 rearm after gmask clear");
    // R8 mask set / clear
    wr(12'h08C, 32'h20);
    chk_rd(12'h084, 32'hFFFF_FFFB, "R8 mask set");
    chk_pin(1, 1'b1, "R8 mask set keeps output");
    wr(12'h048, 32'h1);
    chk_pin(1, 1'b0, "R8 masked source no agreement");
    wr(12'h088, 32'h20);
    chk_pin(1, 1'b1, "R8 mask clear evaluates");
    chk_rd(12'h084, 32'hFFFF_FFDB, "R8 mask clear readback");
    // R3 out-of-range bank, R2 read-only writes
    wr(12'h0E4, 32'h0);
    chk_rd(12'h0E4, 32'h0, "R3 bank3 reads zero");
    chk_rd(12'h084, 32'hFFFF_FFDB, "R3 bank3 write ignored");
    wr(12'h000, 32'h0);
    chk_rd(12'h000, 32'h21, "R2 revision write ignored");
    wr(12'h098, 32'h0);
    chk_rd(12'h098, 32'h20, "R2 pending write ignored");
    wr(12'h080, 32'h0);
    chk_rd(12'h080, 32'h20, "R2 raw write ignored");
    // R12 config, idle and soft reset
    wr(12'h010, 32'h1);
    chk_rd(12'h010, 32'h1, "R12 autoidle stored");
    wr(12'h050, 32'h3);
    chk_rd(12'h050, 32'h3, "R12 idle stored");
    wr(12'h010, 32'h2);
    chk_pin(1, 1'b0, "R12 soft reset output low");
    chk_rd(12'h084, 32'hFFFF_FFFF, "R1 mask after soft reset");
    chk_rd(12'h010, 32'h0, "R1 config after soft reset");
    chk_rd(12'h050, 32'h0, "R1 idle after soft reset");
    chk_rd(12'h114, 32'h0, "R1 line cfg after soft reset");
    chk_rd(12'h040, 32'h0, "R1 code after soft reset");
    chk_rd(12'h048, 32'h0, "R1 control after soft reset");
    chk_rd(12'h080, 32'h20, "R6 raw recaptured after soft reset");
    chk_rd(12'h098, 32'h0, "R5 masked pending hidden");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule